// File: doc/BRIEF.md
# Filtered Quadrature Encoder Position Counter

This block turns the two phase-shifted square waves of an incremental encoder into a binary position value. Each channel is synchronised to the system clock and then passes through a digital persistence filter, so short spikes never reach the decoder. The decoder counts every edge of either channel, which gives four counts per encoder line. The phase order of the two channels selects the count direction: channel A leading channel B counts up.

For each accepted transition the block raises a one-cycle strobe together with a direction level. An external counter can be cascaded from these two signals. The strobe is a valid-only stream with no back-pressure, because an encoder cannot be paused. A downstream consumer must accept a strobe in any cycle. The counter width is set when the block is built, normally 12 or 16 bits, and the count wraps at both ends.

Top module: `quad_counter_top`

## Requirements
- R1: With `rst_n` low, `position` goes to zero at once, without waiting for a clock edge. `step_strobe` and `step_up` read 0, and the filtered channel state is taken as A=0, B=0.
- R2: A filtered channel takes a new level only when its synchronised input has shown that level for 3 consecutive clock samples. A raw pulse lasting 1 or 2 clocks changes neither `position` nor `step_strobe`. A pulse lasting 3 clocks is counted.
- R3: Suppose a single raw channel changes before rising edge k and then stays stable. Then `step_strobe` and the new `position` first appear after rising edge k+5, and not earlier.
- R4: The {A,B} state sequence 00→10→11→01→00 (A leading) increments `position` by exactly one per transition.
- R5: The reverse sequence 00→01→11→10→00 (B leading) decrements `position` by exactly one per transition.
- R6: `step_up` is 1 for an up transition and 0 for a down transition. It keeps its value until the next valid transition.
- R7: If both filtered channels change in the same cycle, the change is illegal. No count and no strobe result. The new state becomes the reference for the next transition.
- R8: `position` wraps modulo 2^CNT_WIDTH in both directions. Each `step_strobe` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| step_strobe | output | 1 | One-cycle pulse per accepted transition |
| step_up | output | 1 | Direction of the latest transition (1 = up) |
| position | output | CNT_WIDTH | Up/down position count |

## Verification
A corrupted filter history or a corrupted synchroniser stage appears as a count that is missing or extra. Such an error becomes visible on `step_strobe` within six clocks of the offending input edge. A stale reference state in the decoder shows up on the next transition as a wrong direction or a count that is not made. This is seen on `step_up` and `position` one cycle after the filtered edge. A counter fault is permanent at the ports: every later `position` read stays off by the error, so a settle-and-compare after each move exposes it at once.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } quad_t;

  // Forward (A leading) order: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic is_forward(quad_t prev, quad_t cur);
    return cur.a ^ prev.b;
  endfunction

endpackage

// File: rtl/qdc_sync_filter.sv
module qdc_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-2:0]    hist_q;
  logic [FILT_LEN-1:0]    window;
  logic                   s_sync;

  assign s_sync = sync_q[SYNC_STAGES-1];
  assign window = {hist_q, s_sync};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      clean  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= window[FILT_LEN-2:0];
      if (&window)
        clean <= 1'b1;
      else if (~|window)
        clean <= 1'b0;
    end
  end

  // R2
  filter_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> $past(s_sync) == clean);

endmodule

// File: rtl/qdc_decoder.sv
module qdc_decoder
  import qdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  quad_t cur,
  output logic  inc,
  output logic  dec,
  output logic  strobe_q,
  output logic  dir_q
);

  quad_t      prev_q;
  logic [1:0] delta;
  logic       step_valid;
  logic       step_fwd;

  assign delta      = {cur.a ^ prev_q.a, cur.b ^ prev_q.b};
  assign step_valid = ^delta;
  assign step_fwd   = is_forward(prev_q, cur);
  assign inc        = step_valid & step_fwd;
  assign dec        = step_valid & ~step_fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      strobe_q <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      prev_q   <= cur;
      strobe_q <= step_valid;
      if (step_valid)
        dir_q <= step_fwd;
    end
  end

  // R7
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&delta) |=> !strobe_q);

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> $stable(dir_q));

endmodule

// File: rtl/qdc_counter.sv
module qdc_counter #(
  parameter int CNT_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic                 dec,
  output logic [CNT_WIDTH-1:0] position
);

  localparam logic [CNT_WIDTH-1:0] ONE = CNT_WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      position <= '0;
    else if (inc)
      position <= position + ONE;
    else if (dec)
      position <= position - ONE;
  end

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> position == $past(position) + ONE);

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> position == $past(position) - ONE);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(position));

endmodule

// File: rtl/quad_counter_top.sv
module quad_counter_top
  import qdc_pkg::*;
#(
  parameter int CNT_WIDTH   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_a,
  input  logic                 enc_b,
  output logic                 step_strobe,
  output logic                 step_up,
  output logic [CNT_WIDTH-1:0] position
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] clean_vec;
  quad_t             cur;
  logic              inc;
  logic              dec;

  assign raw_vec = {enc_a, enc_b};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    qdc_sync_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_vec[ch]),
      .clean(clean_vec[ch])
    );
  end

  assign cur = '{a: clean_vec[1], b: clean_vec[0]};

  qdc_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (cur),
    .inc     (inc),
    .dec     (dec),
    .strobe_q(step_strobe),
    .dir_q   (step_up)
  );

  qdc_counter #(.CNT_WIDTH(CNT_WIDTH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .dec     (dec),
    .position(position)
  );

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe |-> !$stable(position));

endmodule

// File: tb/quad_counter_top_test.sv
`timescale 1ns/1ps
module quad_counter_top_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enc_a = 1'b0;
  logic         enc_b = 1'b0;
  logic         step_strobe;
  logic         step_up;
  logic [W-1:0] position;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int ups = 0;
  logic [W-1:0] exp_pos = '0;
  logic [1:0]   st = 2'b00;  // {A,B}

  always #2 clk = ~clk;

  quad_counter_top #(.CNT_WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .step_strobe(step_strobe), .step_up(step_up), .position(position)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && step_strobe) begin
      pulses++;
      if (step_up) ups++;
    end
  end

  function automatic logic [1:0] next_state(logic [1:0] s, bit up);
    case (s)
      2'b00: return up ? 2'b10 : 2'b01;
      2'b10: return up ? 2'b11 : 2'b00;
      2'b11: return up ? 2'b01 : 2'b10;
      default: return up ? 2'b00 : 2'b11;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic drive(logic [1:0] s);
    @(negedge clk);
    enc_a = s[1];
    enc_b = s[0];
  endtask

  task automatic move(bit up, string req);
    int p0;
    p0 = pulses;
    st = next_state(st, up);
    exp_pos = up ? exp_pos + 1'b1 : exp_pos - 1'b1;
    drive(st);
    settle();
    check(position == exp_pos, req, "position", position, exp_pos);
    check(pulses == p0 + 1, req, "strobe count", pulses, p0 + 1);
    check(step_up == up, "R6", "direction", step_up, up);
  endtask

  task automatic glitch(bit on_a, int len, string req);
    int p0;
    logic [W-1:0] q0;
    p0 = pulses;
    q0 = position;
    @(negedge clk);
    if (on_a) enc_a = ~st[1]; else enc_b = ~st[0];
    repeat (len) @(negedge clk);
    enc_a = st[1];
    enc_b = st[0];
    settle();
    check(position == q0, req, "glitch position", position, q0);
    check(pulses == p0, req, "glitch strobes", pulses, p0);
  endtask

  task automatic illegal(string req);
    int p0;
    p0 = pulses;
    st = ~st;
    drive(st);
    settle();
    check(position == exp_pos, req, "illegal position", position, exp_pos);
    check(pulses == p0, req, "illegal strobes", pulses, p0);
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int p0;
    logic dir0;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(position == 0, "R1", "reset position", position, 0);
    check(step_strobe == 0, "R1", "reset strobe", step_strobe, 0);
    check(step_up == 0, "R1", "reset dir", step_up, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 exact latency, R8 single-cycle strobe
    st = 2'b10;
    drive(st);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(step_strobe == 0, "R3", "early strobe", step_strobe, 0);
    end
    @(negedge clk);
    check(step_strobe == 1, "R3", "strobe at k+5", step_strobe, 1);
    check(position == 1, "R3", "position at k+5", position, 1);
    @(negedge clk);
    check(step_strobe == 0, "R8", "strobe width", step_strobe, 0);
    exp_pos = 1;
    settle();

    // R4 up sequence
    p0 = ups;
    for (int i = 0; i < 3; i++) move(1'b1, "R4");
    check(position == 4, "R4", "full up cycle", position, 4);
    check(ups == p0 + 3, "R4", "up strobes", ups, p0 + 3);

    // R5 down sequence
    for (int i = 0; i < 4; i++) move(1'b0, "R5");
    check(position == 0, "R5", "full down cycle", position, 0);

    // R8 wrap both ways
    move(1'b0, "R8");
    check(position == {W{1'b1}}, "R8", "wrap below zero", position, {W{1'b1}});
    move(1'b1, "R8");
    check(position == 0, "R8", "wrap above max", position, 0);

    // R2 short glitches rejected, R6 direction held
    dir0 = step_up;
    glitch(1'b1, 1, "R2");
    glitch(1'b0, 2, "R2");
    check(step_up == dir0, "R6", "dir held over glitch", step_up, dir0);

    // R7 illegal double change, then resume from new state
    illegal("R7");
    move(1'b1, "R7");
    move(1'b1, "R7");

    // R2 three-cycle pulse counts (out and back)
    p0 = pulses;
    @(negedge clk);
    enc_a = ~st[1];
    repeat (3) @(negedge clk);
    enc_a = st[1];
    settle();
    check(pulses == p0 + 2, "R2", "3-cycle pulse strobes", pulses, p0 + 2);
    check(position == exp_pos, "R2", "3-cycle pulse net", position, exp_pos);

    // R1 asynchronous clear between edges
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(position == 0, "R1", "async clear", position, 0);
    check(step_strobe == 0, "R1", "async strobe", step_strobe, 0);
    enc_a = 1'b0;
    enc_b = 1'b0;
    st = 2'b00;
    exp_pos = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Random mix
    void'($urandom(32'h1ee7c0de));
    for (int n = 0; n < 300; n++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 7)
        move(pick < 4, pick < 4 ? "R4" : "R5");
      else if (pick < 9)
        glitch(pick == 7, int'($urandom_range(1, 2)), "R2");
      else
        illegal("R7");
    end

    summary();
  end

endmodule